// File: doc/BRIEF.md
# Streaming Sobel edge overlay

This block takes a raster stream of 8-bit grayscale pixels and marks edges in it. It accepts at most one pixel per clock. A valid strobe qualifies each pixel. One flag marks the first pixel of a frame and another marks the last pixel of each line. The block keeps a sliding 3x3 neighbourhood of the stream and forms the two Sobel gradients. It divides each gradient by 8, then thresholds the sum of their squares to get a one-bit edge decision.

The edge decision is scaled to full white and mixed with the original centre pixel. The edge term gets a weight of about 0.2 and the pixel gets about 0.8. The block emits this mix as an 8-bit overlay pixel. The edge bit and the frame and line flags of the centre pixel travel with it.

The line width is a parameter. Frames must be exactly that many pixels wide and at least two lines tall. Idle cycles with the strobe low freeze the block completely. The output is the input stream delayed by a fixed number of accepted pixels. The final pixels of a frame therefore leave the block while the next frame is being fed in.

Top module: `sobel_overlay`

## Requirements
- R1: A neighbour of the centre pixel is read as zero when it lies outside the frame. This covers neighbours left of column 0, right of column WIDTH-1, above the first line and below the last line. Pixels of a different frame, and pixels accepted before reset, are never used as neighbours.
- R2: Number the 3x3 window u1..u9 row by row, starting top-left. The horizontal gradient is (u1 + 2*u2 + u3) - (u7 + 2*u8 + u9).
- R3: The vertical gradient is (u1 + 2*u4 + u7) - (u3 + 2*u6 + u9).
- R4: Each gradient is arithmetically shifted right by 3, rounding towards minus infinity. out_edge is 1 exactly when the sum of the squares of the two shifted gradients exceeds 49.
- R5: out_pix = min(255, (205*p + 51*E + 128) >> 8). Here p is the centre pixel and E is 255 when out_edge is 1 and 0 otherwise. So an edge pixel is never below 51 and a non-edge pixel never exceeds 204.
- R6: Exactly one result is produced per accepted input, in raster order. The result for the k-th accepted pixel (counting from 0 since reset, across frames) appears in the cycle after the clock edge that accepts pixel k+WIDTH+4. The first out_valid therefore follows the (WIDTH+5)-th accepted pixel.
- R7: out_sof and out_eol are high together with out_valid on exactly those results whose centre pixel entered with in_sof or in_eol high.
- R8: A cycle with in_valid low changes no state. out_valid is low in the cycle after it, and out_pix holds its value.
- R9: While rst_n is low, out_valid, out_sof and out_eol are low and all stored neighbourhood contents are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eol | input | 1 | Input pixel is the last of a line |
| in_pix | input | 8 | Grayscale input pixel |
| out_valid | output | 1 | Result strobe |
| out_sof | output | 1 | Result belongs to the first pixel of a frame |
| out_eol | output | 1 | Result belongs to the last pixel of a line |
| out_pix | output | 8 | Overlay pixel |
| out_edge | output | 1 | Edge decision for the result |

## Verification
Two things coincide at every frame seam. The bottom line of one frame is still being finished while the first line of the next frame fills the window. Zero-filling by frame must then hide the new frame's pixels from the old frame's bottom row, and hide the old frame's pixels from the new frame's top row, in the same cycles.

The bench provokes this by streaming frames back to back. The patterns carry strong vertical contrast across the seam, including an all-white frame whose border rows become edges only because of zero fill. Every result is compared with a model built from the requirement formulas on each isolated frame. A further run after a mid-stream reset uses a dim flat frame, whose top-row edges appear only if the stale lines are really ignored.

// File: rtl/sobel_overlay.sv
module sobel_overlay #(
  parameter int WIDTH = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eol,
  input  logic [7:0] in_pix,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eol,
  output logic [7:0] out_pix,
  output logic       out_edge
);
  localparam int DEPTH = 2 * WIDTH + 3;
  localparam int CTR   = WIDTH + 1;
  localparam int CW    = $clog2(WIDTH);
  localparam int TAP [9] = '{2*WIDTH+2, 2*WIDTH+1, 2*WIDTH,
                             WIDTH+2,   WIDTH+1,   WIDTH,
                             2,         1,         0};

  logic [7:0]       line_q [DEPTH];
  logic [DEPTH-1:0] fill_q, tag_q;
  logic [CTR:0]     sof_q, eol_q;
  logic             ftag_q;
  logic [CW-1:0]    col_q;

  wire tag_in = in_sof ? ~ftag_q : ftag_q;
  wire [CW-1:0] col_in = in_sof ? '0 : (col_q == CW'(WIDTH-1)) ? '0 : col_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      ftag_q <= 1'b0;
      col_q  <= '0;
    end else if (in_valid) begin
      fill_q <= {fill_q[DEPTH-2:0], 1'b1};
      tag_q  <= {tag_q[DEPTH-2:0], tag_in};
      sof_q  <= {sof_q[CTR-1:0], in_sof};
      eol_q  <= {eol_q[CTR-1:0], in_eol};
      ftag_q <= tag_in;
      col_q  <= col_in;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      line_q[0] <= in_pix;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end

  wire [CW-1:0] cx = (col_q == '0) ? CW'(WIDTH-1) : col_q - CW'(1);
  wire left_ok  = cx != '0;
  wire right_ok = cx != CW'(WIDTH-1);

  logic [7:0] u [9];
  always_comb begin
    for (int k = 0; k < 9; k++) begin
      if (fill_q[TAP[k]] && (tag_q[TAP[k]] == tag_q[CTR]) &&
          !((k % 3 == 0) && !left_ok) && !((k % 3 == 2) && !right_ok))
        u[k] = line_q[TAP[k]];
      else
        u[k] = 8'd0;
    end
  end

  logic signed [11:0] hg_w, vg_w;
  assign hg_w = ({4'd0, u[0]} + {3'd0, u[1], 1'b0} + {4'd0, u[2]})
              - ({4'd0, u[6]} + {3'd0, u[7], 1'b0} + {4'd0, u[8]});
  assign vg_w = ({4'd0, u[0]} + {3'd0, u[3], 1'b0} + {4'd0, u[6]})
              - ({4'd0, u[2]} + {3'd0, u[5], 1'b0} + {4'd0, u[8]});

  logic signed [7:0] hs1, vs1;
  logic [7:0]  p1, pix3;
  logic        v1, sof1, eol1, v2, sof2, eol2, v3, sof3, eol3, edge3, fresh_q;
  logic [15:0] sq2, wp2;

  logic signed [15:0] hsq, vsq;
  assign hsq = hs1 * hs1;
  assign vsq = vs1 * vs1;

  wire edge_w = sq2 > 16'd49;
  wire [8:0] blend_w = 9'(({1'b0, wp2} + (edge_w ? 17'd13005 : 17'd0) + 17'd128) >> 8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v1, v2, v3, sof3, eol3, edge3, fresh_q} <= '0;
      pix3 <= '0;
    end else begin
      fresh_q <= in_valid;
      if (in_valid) begin
        v1   <= fill_q[CTR];
        sof1 <= sof_q[CTR];
        eol1 <= eol_q[CTR];
        p1   <= line_q[CTR];
        hs1  <= 8'(hg_w >>> 3);
        vs1  <= 8'(vg_w >>> 3);
        v2   <= v1;
        sof2 <= sof1;
        eol2 <= eol1;
        sq2  <= $unsigned(hsq) + $unsigned(vsq);
        wp2  <= 16'(p1) * 16'd205;
        v3   <= v2;
        sof3 <= sof2;
        eol3 <= eol2;
        edge3 <= edge_w;
        pix3 <= blend_w[8] ? 8'd255 : blend_w[7:0];
      end
    end
  end

  assign out_valid = fresh_q & v3;
  assign out_sof   = out_valid & sof3;
  assign out_eol   = out_valid & eol3;
  assign out_pix   = pix3;
  assign out_edge  = edge3;

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pix));
  // R5
  edge_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_edge) |-> (out_pix >= 8'd51));
  // R5
  plain_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_edge) |-> (out_pix <= 8'd204));
  // R7
  sync_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eol) |-> out_valid);
endmodule

// File: tb/sobel_overlay_tb.sv
`timescale 1ns/1ps
module sobel_overlay_tb_top;
  localparam int W = 8, H = 6, NV = 8, QN = 1024;
  // stimulus vectors: {kind, lo, hi}
  localparam logic [23:0] VEC [NV] = '{24'h00_64_00, 24'h01_10_F0, 24'h02_20_C8,
    24'h03_05_1E, 24'h04_00_FF, 24'h05_FF_FF, 24'h06_28_B4, 24'h07_00_00};

  logic clk = 0, rst_n = 0, in_valid = 0, in_sof = 0, in_eol = 0;
  logic [7:0] in_pix = 0;
  logic out_valid, out_sof, out_eol, out_edge;
  logic [7:0] out_pix;

  sobel_overlay #(.WIDTH(W)) dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_sof(in_sof), .in_eol(in_eol), .in_pix(in_pix), .out_valid(out_valid),
    .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix), .out_edge(out_edge));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, acc = 0, wr = 0, rd = 0;
  bit seen = 0, done = 0;
  int img [H][W];
  int exp_pix [QN];
  bit exp_edge [QN], exp_sof [QN], exp_eol [QN];

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int at(int y, int x);
    if (y < 0 || y >= H || x < 0 || x >= W) return 0;  // R1 zero fill
    return img[y][x];
  endfunction

  function automatic int gen(int kind, int lo, int hi, int x, int y);
    case (kind)
      0: return lo;
      1: return (x >= W/2) ? hi : lo;
      2: return (y >= H/2) ? hi : lo;
      3: return lo + x * hi;
      4: return ((x + y) % 2 == 1) ? hi : lo;
      5: return hi;
      6: return (x > y) ? hi : lo;
      default: return (x * 37 + y * 91 + 13) & 255;
    endcase
  endfunction

  task automatic load_frame(logic [23:0] v);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        img[y][x] = gen(int'(v[23:16]), int'(v[15:8]), int'(v[7:0]), x, y);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int hg, vg, hs, vs, o;
        bit e;
        // R2 / R3 gradients, R4 shift and threshold, R5 blend
        hg = (at(y-1,x-1) + 2*at(y-1,x) + at(y-1,x+1)) - (at(y+1,x-1) + 2*at(y+1,x) + at(y+1,x+1));
        vg = (at(y-1,x-1) + 2*at(y,x-1) + at(y+1,x-1)) - (at(y-1,x+1) + 2*at(y,x+1) + at(y+1,x+1));
        hs = hg >>> 3;
        vs = vg >>> 3;
        e = (hs*hs + vs*vs) > 49;
        o = (img[y][x] * 205 + (e ? 13005 : 0) + 128) >> 8;
        if (o > 255) o = 255;
        exp_pix[wr] = o; exp_edge[wr] = e;
        exp_sof[wr] = (x == 0 && y == 0); exp_eol[wr] = (x == W-1);
        wr++;
      end
  endtask

  task automatic put(int p, bit s, bit e);
    in_pix = 8'(p); in_sof = s; in_eol = e; in_valid = 1;
    @(posedge clk);
    acc++;
    #1 in_valid = 0;
  endtask

  task automatic idle(int n);
    in_valid = 0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic gap(int n);
    logic [7:0] held;
    in_valid = 0;
    @(negedge clk);
    held = out_pix;
    repeat (n) begin
      @(negedge clk);
      check(out_valid == 0, "R8 idle cycle out_valid", out_valid, 0);
      check(out_pix == held, "R8 idle cycle out_pix held", out_pix, held);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic send_frame();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        put(img[y][x], (x == 0 && y == 0), (x == W-1));
        if ((y * W + x) % 7 == 3) idle(1);
      end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (!seen) begin
        seen = 1;
        check(acc == W + 5, "R6 first output latency", acc, W + 5);
      end
      if (rd < wr) begin
        check(out_pix == exp_pix[rd], "R1/R5 overlay pixel", out_pix, exp_pix[rd]);
        check(out_edge == exp_edge[rd], "R2/R3/R4 edge bit", out_edge, exp_edge[rd]);
        check(out_sof == exp_sof[rd], "R7 out_sof", out_sof, exp_sof[rd]);
        check(out_eol == exp_eol[rd], "R7 out_eol", out_eol, exp_eol[rd]);
      end else check(0, "R6 unexpected output", rd, wr);
      rd++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", rd, wr);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !out_sof && !out_eol, "R9 reset outputs", out_valid, 0);
    @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #1;
    for (int v = 0; v < NV; v++) begin
      load_frame(VEC[v]);
      send_frame();
      if (v == 2) gap(12);
    end
    load_frame(24'h00_09_00);
    send_frame();
    idle(5);
    check(rd == wr - (W + 4), "R6 results pending after flush", rd, wr - (W + 4));

    // R9: reset mid-stream, stale lines must not leak into the new frame
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !out_sof && !out_eol, "R9 reset outputs mid-run", out_valid, 0);
    rd = 0; wr = 0; seen = 0; acc = 0;
    @(posedge clk); #1 rst_n = 1;
    @(posedge clk); #1;
    load_frame(24'h00_14_00);
    send_frame();
    load_frame(24'h07_00_00);
    send_frame();
    idle(5);
    check(rd == wr - (W + 4), "R6 results pending after reset run", rd, wr - (W + 4));
    done = 1;
    finish_run();
  end
endmodule